// File: doc/BRIEF.md
# Configurable UART Frame Engine

This block is the framing core of an asynchronous serial port. A transmit path takes one character at a time from a valid/ready stream into a holding register. It moves the character to a shift register and sends it on `txd` as a start bit, the data bits least significant first, an optional parity bit, and one or two stop bits. A receive path oversamples `rxd` and rebuilds each frame. It places the character in a receive holding register offered as a valid/ready stream, and it raises sticky error flags for overrun, parity, framing and break.

The frame format comes from the 7-bit `line_ctl` word. Bits [1:0] give the character length minus 5. Bit 2 selects two stop bits. Bit 3 enables parity and bit 4 selects even parity. Bit 5 sets stick parity and bit 6 forces a break. Bit timing comes from `baud_tick`, a one-cycle pulse at 16 times the bit rate that is produced outside the block.

Stream rules: a character is accepted on any clock where `tx_valid` and `tx_ready` are both high. `tx_ready` stays low while the transmit holding register is full. `rx_valid` stays high and `rx_data` stays unchanged until a clock where `rx_ready` is high. When a frame completes while `rx_valid` is still high and `rx_ready` is low, the block drops the new character and reports an overrun; a receiver that cannot keep up does not stall the line.

Top module: `uart_frame_engine`

## Requirements
- R1: The character length is 5 + `line_ctl[1:0]` bits (5 to 8). Data bits are sent and received least significant bit first, and `rx_data` holds the received bits with all bits above the length at zero.
- R2: With `line_ctl[2]` clear the transmitter sends one high stop bit; with it set, two.
- R3: With `line_ctl[3]` set and `line_ctl[5]` clear, a parity bit follows the data bits. It makes the count of ones even when `line_ctl[4]` is 1 and odd when it is 0. With `line_ctl[3]` clear, no parity bit is sent or expected.
- R4: With `line_ctl[3]` and `line_ctl[5]` both set, the parity bit is the constant NOT `line_ctl[4]`, both when sent and when checked.
- R5: While `line_ctl[6]` is set, `txd` is held low.
- R6: `tx_ready` is high exactly when the transmit holding register is empty. `sts_temt` is high only when the holding register and the shift register are both empty, so `tx_ready` is high again while a character is still being shifted out.
- R7: A received character raises `rx_valid` and stays on `rx_data`, unchanged, until it is taken with `rx_ready`; after that `rx_valid` goes low.
- R8: A frame that completes while `rx_valid` is high and not being taken sets `sts_oe`; the held character is kept and the new one is dropped.
- R9: A received parity bit that does not match R3/R4 sets `sts_pe`. A low first stop bit sets `sts_fe`. The character is still delivered in both cases.
- R10: A frame whose line stays low from the start bit through the stop bit sets `sts_bi` and `sts_fe` and delivers the character 0. The receiver then waits for the line to return high before it looks for a new start bit.
- R11: `sts_oe`, `sts_pe`, `sts_fe` and `sts_bi` stay set until a clock with `sts_rd` high, which clears them. A new event in the same clock wins over the clear.
- R12: After reset `txd` is 1, `tx_ready` and `sts_temt` are 1, and `rx_valid` and all error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| line_ctl | input | 7 | Frame format: [1:0] length-5, [2] two stop, [3] parity on, [4] even, [5] stick, [6] break |
| tx_data | input | 8 | Character to send |
| tx_valid | input | 1 | Transmit stream valid |
| tx_ready | output | 1 | Transmit holding register empty |
| rx_data | output | 8 | Received character |
| rx_valid | output | 1 | Received character waiting (data ready) |
| rx_ready | input | 1 | Takes the received character |
| sts_rd | input | 1 | Status read strobe; clears the sticky flags |
| sts_temt | output | 1 | Transmitter completely empty |
| sts_oe | output | 1 | Sticky overrun flag |
| sts_pe | output | 1 | Sticky parity error flag |
| sts_fe | output | 1 | Sticky framing error flag |
| sts_bi | output | 1 | Sticky break flag |
| txd | output | 1 | Serial output, idle high |
| rxd | input | 1 | Serial input, idle high |

## Verification
The assertions assume that `rst_n` starts low, and that `tx_valid` holds its character until it is accepted. They also assume that `line_ctl` changes only while both directions are idle, because the break property checks `txd` against the control word of the same clock. The bench drives every input on the falling clock edge. It changes `line_ctl` only between frames, and it sends serial frames to `rxd` at exactly 16 ticks per bit. This keeps the receiver's mid-bit sampling inside each bit.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;

  localparam int unsigned CHAR_W_MAX = 8;

  // Field order matches the line_ctl pin: bit 6 down to bit 0.
  typedef struct packed {
    logic       brk;
    logic       stick;
    logic       even;
    logic       par_en;
    logic       two_stop;
    logic [1:0] len_code;
  } lcr_t;

  typedef enum logic [2:0] {
    TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP
  } tx_state_t;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_WAIT_HI
  } rx_state_t;

  // Keep only the bits that belong to the programmed character length.
  function automatic logic [CHAR_W_MAX-1:0] char_mask(
    input logic [CHAR_W_MAX-1:0] d, input logic [1:0] code);
    logic [CHAR_W_MAX-1:0] m;
    m = {CHAR_W_MAX{1'b1}} >> (2'd3 - code);
    return d & m;
  endfunction

  // Parity bit for a masked character.
  function automatic logic par_calc(input lcr_t l, input logic [CHAR_W_MAX-1:0] d);
    if (l.stick) return ~l.even;
    return l.even ? ^d : ~^d;
  endfunction

endpackage

// File: rtl/uart_fe_tx.sv
module uart_fe_tx
  import uart_fe_pkg::*;
#(
  parameter int unsigned DW  = CHAR_W_MAX,
  parameter int unsigned OSR = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  lcr_t          lcr,
  input  logic [DW-1:0] data,
  input  logic          valid,
  output logic          ready,
  output logic          temt,
  output logic          txd
);
  localparam int unsigned CW = $clog2(OSR);
  localparam int unsigned BW = $clog2(DW);

  tx_state_t     st;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bidx;
  logic [DW-1:0] hold_q, sh_q;
  logic          hold_v, par_q, stop2_q;
  logic          bit_end, last_data;

  assign bit_end   = tick && (cnt == CW'(OSR - 1));
  assign last_data = (int'(bidx) == int'(DW) - 4 + int'(lcr.len_code));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= TX_IDLE;
      cnt     <= '0;
      bidx    <= '0;
      hold_q  <= '0;
      sh_q    <= '0;
      hold_v  <= 1'b0;
      par_q   <= 1'b0;
      stop2_q <= 1'b0;
    end else begin
      if (valid && !hold_v) begin
        hold_q <= data;
        hold_v <= 1'b1;
      end
      if (st != TX_IDLE && tick) cnt <= bit_end ? '0 : cnt + 1'b1;
      unique case (st)
        TX_IDLE: if (hold_v) begin
          sh_q   <= hold_q;
          par_q  <= par_calc(lcr, char_mask(hold_q, lcr.len_code));
          hold_v <= 1'b0;
          cnt    <= '0;
          bidx   <= '0;
          st     <= TX_START;
        end
        TX_START: if (bit_end) st <= TX_DATA;
        TX_DATA: if (bit_end) begin
          sh_q <= sh_q >> 1;
          bidx <= bidx + 1'b1;
          if (last_data) begin
            stop2_q <= 1'b0;
            st      <= lcr.par_en ? TX_PAR : TX_STOP;
          end
        end
        TX_PAR: if (bit_end) st <= TX_STOP;
        TX_STOP: if (bit_end) begin
          if (lcr.two_stop && !stop2_q) stop2_q <= 1'b1;
          else st <= TX_IDLE;
        end
        default: st <= TX_IDLE;
      endcase
    end
  end

  assign ready = !hold_v;
  assign temt  = !hold_v && (st == TX_IDLE);

  always_comb begin
    unique case (st)
      TX_START: txd = 1'b0;
      TX_DATA:  txd = sh_q[0];
      TX_PAR:   txd = par_q;
      default:  txd = 1'b1;
    endcase
    if (lcr.brk) txd = 1'b0;
  end

endmodule

// File: rtl/uart_fe_rx.sv
module uart_fe_rx
  import uart_fe_pkg::*;
#(
  parameter int unsigned DW  = CHAR_W_MAX,
  parameter int unsigned OSR = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  lcr_t          lcr,
  input  logic          rxd,
  input  logic          take,
  output logic [DW-1:0] data,
  output logic          valid,
  output logic          ev_oe,
  output logic          ev_pe,
  output logic          ev_fe,
  output logic          ev_bi
);
  localparam int unsigned CW  = $clog2(OSR);
  localparam int unsigned BW  = $clog2(DW);
  localparam int unsigned MID = OSR / 2 - 1;

  rx_state_t     st;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bidx;
  logic [DW-1:0] sh_q, hold_q;
  logic          hold_v, par_q, zero_q;
  logic          sync1, rin;
  logic          smp, last_data, is_brk, par_bad;
  logic [DW-1:0] aligned;

  assign smp       = tick && (cnt == CW'(OSR - 1));
  assign last_data = (int'(bidx) == int'(DW) - 4 + int'(lcr.len_code));
  assign aligned   = sh_q >> (2'd3 - lcr.len_code);
  assign is_brk    = !rin && zero_q;
  assign par_bad   = lcr.par_en && (par_q != par_calc(lcr, aligned));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b1;
      rin   <= 1'b1;
    end else begin
      sync1 <= rxd;
      rin   <= sync1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= RX_IDLE;
      cnt    <= '0;
      bidx   <= '0;
      sh_q   <= '0;
      hold_q <= '0;
      hold_v <= 1'b0;
      par_q  <= 1'b0;
      zero_q <= 1'b0;
      ev_oe  <= 1'b0;
      ev_pe  <= 1'b0;
      ev_fe  <= 1'b0;
      ev_bi  <= 1'b0;
    end else begin
      ev_oe <= 1'b0;
      ev_pe <= 1'b0;
      ev_fe <= 1'b0;
      ev_bi <= 1'b0;
      if (take) hold_v <= 1'b0;
      if (st != RX_IDLE && st != RX_WAIT_HI && tick) cnt <= smp ? '0 : cnt + 1'b1;
      unique case (st)
        RX_IDLE: if (tick && !rin) begin
          cnt <= CW'(1);
          st  <= RX_START;
        end
        RX_START: if (tick && cnt == CW'(MID)) begin
          cnt    <= '0;
          bidx   <= '0;
          zero_q <= 1'b1;
          par_q  <= 1'b0;
          st     <= rin ? RX_IDLE : RX_DATA;
        end
        RX_DATA: if (smp) begin
          sh_q   <= {rin, sh_q[DW-1:1]};
          zero_q <= zero_q & !rin;
          bidx   <= bidx + 1'b1;
          if (last_data) st <= lcr.par_en ? RX_PAR : RX_STOP;
        end
        RX_PAR: if (smp) begin
          par_q  <= rin;
          zero_q <= zero_q & !rin;
          st     <= RX_STOP;
        end
        RX_STOP: if (smp) begin
          ev_fe <= !rin;
          ev_bi <= is_brk;
          ev_pe <= par_bad && !is_brk;
          if (hold_v && !take) begin
            ev_oe <= 1'b1;
          end else begin
            hold_q <= is_brk ? '0 : aligned;
            hold_v <= 1'b1;
          end
          st <= rin ? RX_IDLE : RX_WAIT_HI;
        end
        RX_WAIT_HI: if (rin) st <= RX_IDLE;
        default: st <= RX_IDLE;
      endcase
    end
  end

  assign data  = hold_q;
  assign valid = hold_v;

endmodule

// File: rtl/uart_fe_flags.sv
module uart_fe_flags #(
  parameter int unsigned NF = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set,
  input  logic          clr,
  output logic [NF-1:0] q
);
  for (genvar i = 0; i < NF; i++) begin : g_flag
    logic f_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) f_q <= 1'b0;
      else        f_q <= set[i] | (f_q & ~clr);
    end
    assign q[i] = f_q;
  end

endmodule

// File: rtl/uart_frame_engine.sv
module uart_frame_engine
  import uart_fe_pkg::*;
#(
  parameter int unsigned DW  = CHAR_W_MAX,
  parameter int unsigned OSR = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic [6:0]    line_ctl,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_valid,
  output logic          tx_ready,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  input  logic          rx_ready,
  input  logic          sts_rd,
  output logic          sts_temt,
  output logic          sts_oe,
  output logic          sts_pe,
  output logic          sts_fe,
  output logic          sts_bi,
  output logic          txd,
  input  logic          rxd
);
  localparam int unsigned NFLAG = 4;

  lcr_t             lcr;
  logic [NFLAG-1:0] ev, flags;
  logic             ev_oe, ev_pe, ev_fe, ev_bi;

  assign lcr = lcr_t'(line_ctl);

  uart_fe_tx #(.DW(DW), .OSR(OSR)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .lcr(lcr),
    .data(tx_data), .valid(tx_valid), .ready(tx_ready),
    .temt(sts_temt), .txd(txd)
  );

  uart_fe_rx #(.DW(DW), .OSR(OSR)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .lcr(lcr),
    .rxd(rxd), .take(rx_ready), .data(rx_data), .valid(rx_valid),
    .ev_oe(ev_oe), .ev_pe(ev_pe), .ev_fe(ev_fe), .ev_bi(ev_bi)
  );

  assign ev = {ev_bi, ev_fe, ev_pe, ev_oe};

  uart_fe_flags #(.NF(NFLAG)) u_flags (
    .clk(clk), .rst_n(rst_n), .set(ev), .clr(sts_rd), .q(flags)
  );

  assign sts_oe = flags[0];
  assign sts_pe = flags[1];
  assign sts_fe = flags[2];
  assign sts_bi = flags[3];

endmodule

// File: rtl/uart_fe_chk.sv
module uart_fe_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [6:0]    line_ctl,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [DW-1:0] rx_data,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic          sts_rd,
  input logic          sts_temt,
  input logic          sts_oe,
  input logic          sts_pe,
  input logic          sts_fe,
  input logic          sts_bi,
  input logic          txd
);

  p_reset_r12: assert property (@(posedge clk)
    $rose(rst_n) |-> tx_ready && sts_temt && !rx_valid && txd);

  p_break_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    line_ctl[6] |-> !txd);

  p_temt_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sts_temt |-> tx_ready);

  p_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> !tx_ready && !sts_temt);

  p_rx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data));

  p_oe_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sts_oe && !sts_rd |=> sts_oe);

  p_pe_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sts_pe && !sts_rd |=> sts_pe);

  p_fe_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sts_fe && !sts_rd |=> sts_fe);

  p_bi_fe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sts_bi |-> sts_fe);

endmodule

bind uart_frame_engine uart_fe_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_ctl(line_ctl), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .sts_rd(sts_rd), .sts_temt(sts_temt),
  .sts_oe(sts_oe), .sts_pe(sts_pe), .sts_fe(sts_fe), .sts_bi(sts_bi),
  .txd(txd)
);

// File: tb/uart_frame_engine_tb.sv
module uart_frame_engine_tb;
  localparam int BIT_CLK = 32;   // 16 ticks per bit, one tick every 2 clocks
  localparam int NVEC    = 7;

  // {line_ctl[6:0], tx char[7:0], expected rx char[7:0], expected parity bit}
  localparam logic [23:0] VEC [NVEC] = '{
    {7'h03, 8'hA5, 8'hA5, 1'b0},
    {7'h1A, 8'hC3, 8'h43, 1'b1},
    {7'h0C, 8'h3F, 8'h1F, 1'b0},
    {7'h39, 8'h2A, 8'h2A, 1'b0},
    {7'h2B, 8'h00, 8'h00, 1'b1},
    {7'h0F, 8'hFF, 8'hFF, 1'b1},
    {7'h09, 8'h15, 8'h15, 1'b0}
  };

  logic       clk = 1'b0, rst_n = 1'b0, baud_tick = 1'b0;
  logic [6:0] line_ctl = 7'h03;
  logic [7:0] tx_data = '0, rx_data;
  logic       tx_valid = 1'b0, tx_ready, rx_valid, rx_ready = 1'b0, sts_rd = 1'b0;
  logic       sts_temt, sts_oe, sts_pe, sts_fe, sts_bi, txd, rxd;
  logic       loop_en = 1'b1, drv_rxd = 1'b1;
  int         n_chk = 0, n_fail = 0;

  assign rxd = loop_en ? txd : drv_rxd;

  always #2.5 clk = ~clk;
  always @(posedge clk) baud_tick <= ~baud_tick;

  uart_frame_engine u_dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .line_ctl(line_ctl),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .sts_rd(sts_rd), .sts_temt(sts_temt), .sts_oe(sts_oe), .sts_pe(sts_pe),
    .sts_fe(sts_fe), .sts_bi(sts_bi), .txd(txd), .rxd(rxd)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_tx(input logic [7:0] d);
    @(negedge clk);
    tx_data  = d;
    tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  // Watches txd for one frame; returns data, parity and stop samples.
  task automatic grab_tx(input int nbits, input bit has_par, input int nstop,
                         output logic [7:0] d, output logic p, output logic [1:0] s);
    d = '0; p = 1'b0; s = 2'b00;
    while (txd) @(negedge clk);
    repeat (BIT_CLK / 2) @(negedge clk);
    chk("R1 start bit low", 32'(txd), 32'd0);
    for (int i = 0; i < nbits; i++) begin
      repeat (BIT_CLK) @(negedge clk);
      d[i] = txd;
    end
    if (has_par) begin
      repeat (BIT_CLK) @(negedge clk);
      p = txd;
    end
    for (int i = 0; i < nstop; i++) begin
      repeat (BIT_CLK) @(negedge clk);
      s[i] = txd;
    end
  endtask

  task automatic drive_frame(input int nbits, input logic [7:0] d, input bit has_par,
                             input logic p, input logic stopv);
    @(negedge clk);
    drv_rxd = 1'b0;
    repeat (BIT_CLK) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      drv_rxd = d[i];
      repeat (BIT_CLK) @(negedge clk);
    end
    if (has_par) begin
      drv_rxd = p;
      repeat (BIT_CLK) @(negedge clk);
    end
    drv_rxd = stopv;
    repeat (BIT_CLK) @(negedge clk);
    drv_rxd = 1'b1;
    repeat (BIT_CLK) @(negedge clk);
  endtask

  task automatic wait_rx(input string req);
    int n = 0;
    while (!rx_valid && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk(req, 32'(rx_valid), 32'd1);
  endtask

  task automatic pop_rx();
    @(negedge clk); rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;
  endtask

  task automatic clear_sts();
    @(negedge clk); sts_rd = 1'b1;
    @(negedge clk); sts_rd = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] got_d;
    logic       got_p;
    logic [1:0] got_s;
    repeat (5) @(negedge clk);
    // R12: reset state
    chk("R12 txd idle", 32'(txd), 32'd1);
    chk("R12 tx_ready", 32'(tx_ready), 32'd1);
    chk("R12 temt", 32'(sts_temt), 32'd1);
    chk("R12 rx_valid", 32'(rx_valid), 32'd0);
    chk("R12 flags", 32'({sts_oe, sts_pe, sts_fe, sts_bi}), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Table of frame formats, sent through the loop from txd to rxd.
    for (int v = 0; v < NVEC; v++) begin
      logic [6:0] c;
      int         nb;
      c        = VEC[v][23:17];
      nb       = 5 + int'(c[1:0]);
      line_ctl = c;
      fork
        send_tx(VEC[v][16:9]);
        grab_tx(nb, c[3], c[2] ? 2 : 1, got_d, got_p, got_s);
      join
      chk("R1 tx data bits", 32'(got_d), 32'(VEC[v][8:1]));
      if (c[3]) chk(c[5] ? "R4 stick parity bit" : "R3 parity bit", 32'(got_p), 32'(VEC[v][0]));
      chk("R2 stop bits", 32'(got_s), c[2] ? 32'd3 : 32'd1);
      wait_rx("R7 rx_valid after frame");
      chk("R1 rx char", 32'(rx_data), 32'(VEC[v][8:1]));
      chk("R9 no false errors", 32'({sts_oe, sts_pe, sts_fe, sts_bi}), 32'd0);
      pop_rx();
      chk("R7 rx_valid cleared by take", 32'(rx_valid), 32'd0);
      repeat (BIT_CLK) @(negedge clk);
    end

    // R6: holding register frees while the shifter is busy
    line_ctl = 7'h03;
    send_tx(8'h5A);
    repeat (3) @(negedge clk);
    chk("R6 tx_ready while shifting", 32'(tx_ready), 32'd1);
    chk("R6 temt low while shifting", 32'(sts_temt), 32'd0);
    begin
      int n = 0;
      while (!sts_temt && n < 1000) begin @(negedge clk); n++; end
    end
    chk("R6 temt after frame", 32'(sts_temt), 32'd1);
    wait_rx("R7 loop char");
    pop_rx();

    // R5: forced break on txd
    loop_en  = 1'b0;
    line_ctl = 7'h43;
    repeat (4) @(negedge clk);
    chk("R5 txd low during break", 32'(txd), 32'd0);
    line_ctl = 7'h03;
    repeat (2) @(negedge clk);
    chk("R5 txd idle after break", 32'(txd), 32'd1);
    chk("R5 nothing received from break", 32'(rx_valid), 32'd0);

    // R9: parity error; 8 bits, even parity; 0x01 needs parity 1
    line_ctl = 7'h1B;
    drive_frame(8, 8'h01, 1'b1, 1'b0, 1'b1);
    wait_rx("R9 char with bad parity");
    chk("R9 pe set", 32'(sts_pe), 32'd1);
    chk("R9 char kept", 32'(rx_data), 32'h01);
    pop_rx();
    // R11: stays set across a good frame (0x03 even parity 0)
    drive_frame(8, 8'h03, 1'b1, 1'b0, 1'b1);
    wait_rx("R11 good frame");
    chk("R11 pe sticky", 32'(sts_pe), 32'd1);
    pop_rx();
    clear_sts();
    chk("R11 pe cleared by read", 32'(sts_pe), 32'd0);

    // R9: framing error, 0x55 has even parity 0
    drive_frame(8, 8'h55, 1'b1, 1'b0, 1'b0);
    wait_rx("R9 char with bad stop");
    chk("R9 fe set", 32'(sts_fe), 32'd1);
    chk("R9 fe is not break", 32'(sts_bi), 32'd0);
    chk("R9 fe char kept", 32'(rx_data), 32'h55);
    pop_rx();
    clear_sts();

    // R10: break on the line
    @(negedge clk);
    drv_rxd = 1'b0;
    repeat (BIT_CLK * 14) @(negedge clk);
    chk("R10 bi set", 32'(sts_bi), 32'd1);
    chk("R10 fe with break", 32'(sts_fe), 32'd1);
    chk("R10 zero char", 32'(rx_data), 32'h00);
    pop_rx();
    repeat (BIT_CLK * 2) @(negedge clk);
    chk("R10 single char while line low", 32'(rx_valid), 32'd0);
    drv_rxd = 1'b1;
    repeat (BIT_CLK * 2) @(negedge clk);
    clear_sts();
    chk("R11 bi cleared", 32'(sts_bi), 32'd0);

    // R8: overrun keeps the older character
    drive_frame(8, 8'h11, 1'b1, 1'b0, 1'b1);
    drive_frame(8, 8'h22, 1'b1, 1'b0, 1'b1);
    chk("R8 oe set", 32'(sts_oe), 32'd1);
    chk("R8 old char kept", 32'(rx_data), 32'h11);
    chk("R7 still valid", 32'(rx_valid), 32'd1);
    pop_rx();
    clear_sts();
    chk("R11 oe cleared", 32'(sts_oe), 32'd0);

    finish_run();
  end

endmodule